// File: doc/BRIEF.md
# Serial Canonical Signed-Digit Recoder

The recoder takes a signed two's-complement word and rewrites it as a string of ternary digits, each worth -1, 0 or +1. No two neighbouring digits are both nonzero, which gives the sparsest signed-digit form of the value. A constant-coefficient multiplier built from this form needs one adder or subtractor per nonzero digit. Those adders are outside this block. Its job ends at the digit string and a count of its nonzero entries.

A one-cycle `start` pulse while idle captures `word_in`. From the next clock the block walks the word from the least significant position upward and resolves one digit per clock. It covers W+1 positions, the word widened by one copy of its sign bit. When the last digit is written, `busy` falls and `done` pulses for one cycle. The digit vector and the count then stay stable until the next accepted start, which clears them. A start that arrives during a conversion is dropped.

Top module: `csd_recoder`

## Requirements
- R1: Each digit occupies two bits of `digits`. Digit j sits at bits [2j+1:2j]. The code 2'b00 means 0, 2'b01 means +1 and 2'b11 means -1. The code 2'b10 never appears.
- R2: Two adjacent digits are never both nonzero.
- R3: When `done` is high, the sum over j of digit j times 2^j equals the signed value of the captured word.
- R4: The top digit, at position W, is zero for every input word.
- R5: A `start` seen while `busy` is low makes `busy` high on the next cycle. `busy` stays high for exactly W+1 cycles. `done` is then high for exactly one cycle, with `busy` low.
- R6: A `start` seen while `busy` is high is ignored. It changes neither the captured word nor the timing of the conversion in progress.
- R7: `nz_count` always equals the number of nonzero digits currently held in `digits`.
- R8: `nz_count` never exceeds ceil((W+1)/2).
- R9: After reset, `busy` and `done` are low, and `digits` and `nz_count` are zero.
- R10: The digit string equals the unique non-adjacent signed-digit form of the input value.
- R11: While idle, `digits` and `nz_count` keep the last result. An accepted start clears both to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| word_in | input | W | Signed two's-complement word, sampled on an accepted start |
| start | input | 1 | Begin a conversion; ignored while busy |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when the digit vector is complete |
| digits | output | 2*(W+1) | Packed digit codes, digit j at bits [2j+1:2j] |
| nz_count | output | $clog2(W+2) | Number of nonzero digits held |

## Verification
Some properties are checked on every clock by assertions:
- no digit ever carries the illegal code (R1);
- no two adjacent digits are ever both nonzero (R2);
- the count register agrees with the digit registers and stays within its bound (R7, R8);
- the top digit is zero at completion (R4);
- `done` is a single pulse that follows a busy period (R5).

Other behaviour only the bench scenarios can show:
- the value carried by the digits (R3, R10), which the bench checks exhaustively for an 8-bit word against a mod-4 non-adjacent-form derivation;
- the exact length of the busy window (R5);
- that a restart in mid-run is dropped (R6);
- that results hold and then clear across runs (R11).

// File: rtl/csd_pkg.sv
package csd_pkg;

  typedef logic [1:0] csd_dig_t;

  localparam csd_dig_t DIG_ZERO  = 2'b00;
  localparam csd_dig_t DIG_PLUS  = 2'b01;
  localparam csd_dig_t DIG_MINUS = 2'b11;

  typedef struct packed {
    logic     nz;
    csd_dig_t dig;
  } csd_step_t;

  // One position of the recurrence: the digit is nonzero when the current
  // bit differs from the one below it and the previous digit was zero.
  // Its sign comes from the bit above.
  function automatic csd_step_t csd_step(input logic bit_up,
                                         input logic bit_here,
                                         input logic bit_down,
                                         input logic prev_nz);
    csd_step_t r;
    r.nz  = (bit_here ^ bit_down) & ~prev_nz;
    r.dig = r.nz ? (bit_up ? DIG_MINUS : DIG_PLUS) : DIG_ZERO;
    return r;
  endfunction

  // Upper bound on nonzero digits in an n-digit non-adjacent string.
  function automatic int unsigned csd_max_nz(input int unsigned n);
    return (n + 1) / 2;
  endfunction

endpackage

// File: rtl/csd_seq_ctrl.sv
module csd_seq_ctrl #(
  parameter int W = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start,
  output logic                           busy,
  output logic                           done,
  output logic                           load,
  output logic                           step,
  output logic                           last_step,
  output logic [$clog2(W+2)-1:0]         step_idx
);
  localparam int N  = W + 1;
  localparam int IW = $clog2(W + 2);

  logic          busy_q;
  logic          done_q;
  logic [IW-1:0] idx_q;

  assign load      = start & ~busy_q;
  assign step      = busy_q;
  assign last_step = busy_q && (idx_q == IW'(N - 1));
  assign step_idx  = idx_q;
  assign busy      = busy_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      done_q <= last_step;
      if (load) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (busy_q) begin
        if (last_step) begin
          busy_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + IW'(1);
        end
      end
    end
  end

  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_busy_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  p_start_accept_r5: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && step_idx == '0));

  p_restart_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (start && busy && !last_step) |=> (busy && step_idx == $past(step_idx) + IW'(1)));

endmodule

// File: rtl/csd_bit_window.sv
module csd_bit_window #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] word,
  output logic         bit_up,
  output logic         bit_here,
  output logic         bit_down
);
  localparam int EW = W + 2;

  logic [EW-1:0] sh_q;
  logic          low_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      low_q <= 1'b0;
    end else if (load) begin
      sh_q  <= {word[W-1], word[W-1], word};
      low_q <= 1'b0;
    end else if (step) begin
      sh_q  <= {sh_q[EW-1], sh_q[EW-1:1]};
      low_q <= sh_q[0];
    end
  end

  assign bit_here = sh_q[0];
  assign bit_up   = sh_q[1];
  assign bit_down = low_q;

endmodule

// File: rtl/csd_digit_store.sv
module csd_digit_store
  import csd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic                       step,
  input  logic [$clog2(W+2)-1:0]     step_idx,
  input  logic                       bit_up,
  input  logic                       bit_here,
  input  logic                       bit_down,
  output logic [2*(W+1)-1:0]         digits,
  output logic [$clog2(W+2)-1:0]     nz_count
);
  localparam int N     = W + 1;
  localparam int CW    = $clog2(W + 2);
  localparam int MAXNZ = csd_max_nz(N);

  logic [2*N-1:0] dig_q;
  logic [CW-1:0]  cnt_q;
  logic           prev_nz_q;
  logic [N-1:0]   nz_mask;
  csd_step_t      cur;

  assign cur = csd_step(bit_up, bit_here, bit_down, prev_nz_q);

  always_ff @(posedge clk) begin
    if (rst || load) begin
      cnt_q     <= '0;
      prev_nz_q <= 1'b0;
    end else if (step) begin
      prev_nz_q <= cur.nz;
      if (cur.nz) cnt_q <= cnt_q + CW'(1);
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_pos
    always_ff @(posedge clk) begin
      if (rst || load) begin
        dig_q[2*j +: 2] <= DIG_ZERO;
      end else if (step && step_idx == CW'(j)) begin
        dig_q[2*j +: 2] <= cur.dig;
      end
    end
    assign nz_mask[j] = dig_q[2*j];

    p_legal_code_r1: assert property (@(posedge clk) disable iff (rst)
      dig_q[2*j +: 2] != 2'b10);
  end

  for (genvar j = 0; j < N - 1; j++) begin : g_adj
    p_no_adjacent_r2: assert property (@(posedge clk) disable iff (rst)
      !(dig_q[2*j] && dig_q[2*j+2]));
  end

  p_count_match_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_q == CW'($countones(nz_mask)));

  p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(MAXNZ));

  assign digits   = dig_q;
  assign nz_count = cnt_q;

endmodule

// File: rtl/csd_recoder.sv
module csd_recoder #(
  parameter int W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [W-1:0]           word_in,
  input  logic                   start,
  output logic                   busy,
  output logic                   done,
  output logic [2*(W+1)-1:0]     digits,
  output logic [$clog2(W+2)-1:0] nz_count
);
  localparam int IW = $clog2(W + 2);

  logic          load;
  logic          step;
  logic          last_step;
  logic [IW-1:0] step_idx;
  logic          bit_up;
  logic          bit_here;
  logic          bit_down;

  csd_seq_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .load      (load),
    .step      (step),
    .last_step (last_step),
    .step_idx  (step_idx)
  );

  csd_bit_window #(.W(W)) u_window (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step     (step),
    .word     (word_in),
    .bit_up   (bit_up),
    .bit_here (bit_here),
    .bit_down (bit_down)
  );

  csd_digit_store #(.W(W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step     (step),
    .step_idx (step_idx),
    .bit_up   (bit_up),
    .bit_here (bit_here),
    .bit_down (bit_down),
    .digits   (digits),
    .nz_count (nz_count)
  );

  p_top_digit_zero_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (digits[2*W +: 2] == 2'b00));

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (!busy && !done && digits == '0 && nz_count == '0));

  p_hold_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start && !done) |=> ($stable(digits) && $stable(nz_count)));

endmodule

// File: tb/csd_recoder_tb.sv
module csd_recoder_tb_top;
  localparam int W  = 8;
  localparam int N  = W + 1;
  localparam int CW = $clog2(W + 2);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [W-1:0]   word = '0;
  logic           busy;
  logic           done;
  logic [2*N-1:0] digits;
  logic [CW-1:0]  nz_count;

  always #10 clk = ~clk;

  csd_recoder #(.W(W)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .word_in  (word),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .digits   (digits),
    .nz_count (nz_count)
  );

  int compared   = 0;
  int mismatched = 0;
  int cyc        = 0;

  bit             m_busy = 0;
  bit             m_done = 0;
  int             m_rem  = 0;
  logic [W-1:0]   m_word = '0;
  logic [2*N-1:0] m_digits = '0;
  int             m_count = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // Reference digits by the mod-4 rule: an odd remainder picks +1 or -1 so
  // that the next remainder is even, which forces a zero digit after it.
  function automatic void ref_digits(input int value, output logic [2*N-1:0] enc,
                                     output int cnt);
    int v;
    v   = value;
    enc = '0;
    cnt = 0;
    for (int j = 0; j < N; j++) begin
      int d;
      d = 0;
      if ((v & 1) != 0) d = ((v & 3) == 1) ? 1 : -1;
      v = (v - d) >>> 1;
      if (d == 1)  enc[2*j +: 2] = 2'b01;
      if (d == -1) enc[2*j +: 2] = 2'b11;
      if (d != 0)  cnt++;
    end
  endfunction

  function automatic int dec(input logic [1:0] c);
    case (c)
      2'b00:   return 0;
      2'b01:   return 1;
      2'b11:   return -1;
      default: return 99;
    endcase
  endfunction

  // Behavioural model, advanced on each rising edge from inputs that were
  // driven well away from the edge.
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_busy = 0; m_done = 0; m_rem = 0; m_digits = '0; m_count = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_rem--;
        if (m_rem == 0) begin
          m_busy = 0;
          m_done = 1;
          ref_digits(int'($signed(m_word)), m_digits, m_count);
        end
      end else if (start) begin
        m_busy = 1;
        m_rem  = N;
        m_word = word;
        m_digits = '0;
        m_count  = 0;
      end
    end
    if (cyc == 150000) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(busy == m_busy, "R5", "busy", busy, m_busy);
      check(done == m_done, "R5", "done", done, m_done);
      if (!m_busy) begin
        // R9 before any run, R11 between runs, R10 at completion
        check(digits == m_digits, "R10/R11", "digit vector", digits, m_digits);
        check(int'(nz_count) == m_count, "R7", "nonzero count", nz_count, m_count);
      end
      if (m_done) begin
        int  sum;
        bit  legal;
        bit  adj_ok;
        int  ones;
        sum = 0; legal = 1; adj_ok = 1; ones = 0;
        for (int j = 0; j < N; j++) begin
          int d;
          d = dec(digits[2*j +: 2]);
          if (d == 99) legal = 0; else sum += d * (1 << j);
          if (d != 0 && d != 99) ones++;
          if (j > 0 && d != 0 && dec(digits[2*j-2 +: 2]) != 0) adj_ok = 0;
        end
        check(legal, "R1", "legal codes", legal, 1);
        check(adj_ok, "R2", "no adjacent nonzero", adj_ok, 1);
        check(sum == int'($signed(m_word)), "R3", "weighted sum", sum, int'($signed(m_word)));
        check(digits[2*W +: 2] == 2'b00, "R4", "top digit", digits[2*W +: 2], 0);
        check(ones <= (N + 1) / 2, "R8", "nonzero bound", ones, (N + 1) / 2);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R9", "reset handshake", {busy, done}, 0);
    check(digits == '0 && nz_count == '0, "R9", "reset outputs", digits, 0);
    for (int v = 0; v < (1 << W); v++) begin
      @(posedge clk);
      #2 word = W'(v); start = 1'b1;
      @(posedge clk);
      #2 start = 1'b0;
      if (v % 5 == 2) begin
        // R6: a second start in mid-run with a different word must be dropped
        @(posedge clk);
        #2 word = ~W'(v); start = 1'b1;
        repeat (2) @(posedge clk);
        #2 start = 1'b0;
      end
      repeat (N + 2) @(posedge clk);
    end
    repeat (3) @(posedge clk);
    #2;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule